// File: doc/BRIEF.md
# Multi-Scheme Transmit Keying Controller

This block turns a serial transmit bit stream into control values for a fractional-N synthesizer and a power-amplifier DAC. It supports four keying schemes. Binary frequency keying and its smoothed variant change the synthesizer's fractional offset. Amplitude keying and on/off keying change the DAC code. The block runs on the phase-detector clock, so one offset unit equals one synthesizer frequency step, Fpfd/4096.

One 7-bit word has two uses. In frequency keying it is the deviation magnitude. In amplitude keying it is the power code sent for a zero bit. For the smoothed frequency scheme the block derives its own bit clock from two dividers:

- a programmable pre-divider;
- a sub-step count of 16, 32, 64 or 128.

The bit clock is driven out so that the data source can present bits in step with it. Instead of a true Gaussian filter, the offset moves in a straight-line ramp across the sub-steps of each bit, with floor rounding at every sub-step.

Top module: `tx_keyer`

## Requirements
- R1: `scheme` selects the keying mode: 2'b00 binary frequency keying, 2'b01 smoothed frequency keying, 2'b10 amplitude keying, 2'b11 on/off keying. After reset `freq_ofs`, `pa_code` and `tx_clk` are all zero when `scheme` is 2'b11.
- R2: In binary frequency keying, the data bit captured at each clock edge sets `freq_ofs`. A 1 gives +`dev_word` and a 0 gives -`dev_word`. The new value is visible after that edge. A `dev_word` of 0 gives an offset of 0.
- R3: In amplitude keying, `freq_ofs` is 0. The captured bit selects `hi_word` for a 1 and `dev_word` for a 0 as the candidate DAC code.
- R4: In on/off keying, `freq_ofs` is 0. The candidate DAC code is `hi_word` for a 1 and zero for a 0.
- R5: Bits [6:5] of a power word are its range and bits [4:0] are its level. If the candidate word's range is 2'b00, `pa_code` is all zeros. Otherwise `pa_code` equals the candidate word. In both frequency schemes the candidate is `hi_word`.
- R6: When `pa_en` is 0, `pa_code` is 0 whatever the data and the scheme.
- R7: When `data_inv` is 1, the data bit is inverted before it is captured, in every scheme.
- R8: In smoothed frequency keying, each bit's target offset is +2^`gmod` for a 1 and -2^`gmod` for a 0.
- R9: In smoothed frequency keying, one sub-step lasts max(`div_factor`,1) clocks. One bit lasts C sub-steps, where `idx_sel` 0, 1, 2, 3 gives C = 16, 32, 64, 128. Counting starts from zero when the scheme becomes 2'b01.
- R10: `tx_clk` is high during the first C/2 sub-steps of each bit and low during the rest. It is held low in every other scheme.
- R11: During sub-step s (0-based) of a bit, `freq_ofs` = S + floor((T−S)·(s+1)/C). Here T is the target of the last bit captured and S is the target captured before it. Both are taken as 0 until they have been captured, so the ramp lands exactly on T in the final sub-step.
- R12: In smoothed frequency keying, `tx_data` is captured only at the clock edge that ends a bit. This is the same edge at which `tx_clk` rises. Values of `tx_data` at any other edge have no effect on `freq_ofs`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase-detector clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data | input | 1 | Serial transmit bit |
| data_inv | input | 1 | Invert transmit data |
| pa_en | input | 1 | Power-amplifier enable |
| scheme | input | 2 | Keying scheme select |
| dev_word | input | 7 | Deviation (frequency keying) or zero-bit power word (amplitude keying) |
| hi_word | input | 7 | One-bit power word |
| gmod | input | 3 | Smoothed deviation exponent |
| div_factor | input | 7 | Sub-step pre-divider |
| idx_sel | input | 2 | Sub-step count select |
| freq_ofs | output | 9 | Signed synthesizer offset in frequency steps |
| pa_code | output | 7 | Power-amplifier DAC code |
| tx_clk | output | 1 | Bit-rate clock for smoothed frequency keying |

## Verification
The smoothed scheme is swept over every deviation exponent, every sub-step count and the pre-divider values 0, 1, 2 and 3. The expected ramp is recomputed every cycle. This catches an off-by-one in the sub-step index, which would miss the target in the last sub-step. It also catches truncation toward zero instead of floor, which would be off by one on falling ramps. Between sample edges `tx_data` is driven to the opposite value, so a design that captured data on the wrong edge would send its ramp the wrong way. The other three schemes are swept over data, inversion, enable and power words with range 2'b00. That exposes any confusion between the dual-use word's two roles, and any missing forced-off behaviour.

// File: rtl/tx_key_pkg.sv
package tx_key_pkg;
  typedef enum logic [1:0] {
    KEY_FSK  = 2'b00,
    KEY_GFSK = 2'b01,
    KEY_ASK  = 2'b10,
    KEY_OOK  = 2'b11
  } key_scheme_e;
endpackage

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int DIVF_W        = 7,
  parameter int IDX_W         = 2,
  parameter int IDX_BASE_LOG2 = 4,
  parameter int SUB_W         = IDX_BASE_LOG2 + (1 << IDX_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [DIVF_W-1:0] div_factor,
  input  logic [IDX_W-1:0]  idx_sel,
  output logic              sub_tick,
  output logic              bit_tick,
  output logic [SUB_W-1:0]  sub_idx,
  output logic              tx_clk
);
  logic [DIVF_W-1:0] pre_q, pre_d, div_last;
  logic [SUB_W-1:0]  sub_q, sub_d, idx_last;
  logic [SUB_W:0]    idx_count, idx_last_w, idx_half;

  // sub-step count per bit is a power of two picked by idx_sel
  always_comb begin
    idx_count  = (SUB_W+1)'(1) << (IDX_BASE_LOG2 + int'(idx_sel));
    idx_last_w = idx_count - 1'b1;
    idx_last   = idx_last_w[SUB_W-1:0];
    idx_half   = idx_count >> 1;
    div_last   = (div_factor == '0) ? '0 : div_factor - 1'b1;
  end

  always_comb begin
    sub_tick = run && (pre_q == div_last);
    bit_tick = sub_tick && (sub_q == idx_last);
    tx_clk   = run && ({1'b0, sub_q} < idx_half);
    sub_idx  = sub_q;
  end

  // next state
  always_comb begin
    pre_d = pre_q;
    sub_d = sub_q;
    if (!run) begin
      pre_d = '0;
      sub_d = '0;
    end else begin
      pre_d = sub_tick ? '0 : pre_q + 1'b1;
      if (bit_tick)      sub_d = '0;
      else if (sub_tick) sub_d = sub_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      sub_q <= '0;
    end else begin
      pre_q <= pre_d;
      sub_q <= sub_d;
    end
  end

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sub_q == '0 && pre_q == '0)); // R9
  AST_CLK_RISES_AT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && run) |=> (tx_clk || !run)); // R10
endmodule

// File: rtl/tx_freq_shaper.sv
module tx_freq_shaper
  import tx_key_pkg::*;
#(
  parameter int OFS_W         = 9,
  parameter int DEV_W         = 7,
  parameter int MOD_W         = 3,
  parameter int IDX_W         = 2,
  parameter int IDX_BASE_LOG2 = 4,
  parameter int SUB_W         = IDX_BASE_LOG2 + (1 << IDX_W) - 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  key_scheme_e             sch,
  input  logic                    bit_q,
  input  logic                    data_in,
  input  logic [DEV_W-1:0]        dev_word,
  input  logic [MOD_W-1:0]        gmod,
  input  logic                    sub_tick,
  input  logic                    bit_tick,
  input  logic [SUB_W-1:0]        sub_idx,
  input  logic [IDX_W-1:0]        idx_sel,
  output logic signed [OFS_W-1:0] freq_ofs
);
  localparam int PROD_W = OFS_W + SUB_W + 3;

  logic                     gfsk;
  logic signed [OFS_W-1:0]  start_q, start_d, tgt_q, tgt_d;
  logic signed [OFS_W-1:0]  mag, new_tgt, dev_ext, ramp;
  logic signed [OFS_W:0]    diff;
  logic [SUB_W:0]           step_n;
  logic signed [PROD_W-1:0] prod, scaled, sum;

  always_comb begin
    gfsk    = (sch == KEY_GFSK);
    mag     = OFS_W'(1) << gmod;
    new_tgt = data_in ? mag : -mag;
    dev_ext = $signed({{(OFS_W-DEV_W){1'b0}}, dev_word});
  end

  // linear ramp from previous target to current target, floor rounded
  always_comb begin
    diff   = $signed({tgt_q[OFS_W-1], tgt_q}) - $signed({start_q[OFS_W-1], start_q});
    step_n = {1'b0, sub_idx} + 1'b1;
    prod   = PROD_W'(diff) * $signed(PROD_W'(step_n));
    scaled = prod >>> (IDX_BASE_LOG2 + int'(idx_sel));
    sum    = PROD_W'(start_q) + scaled;
    ramp   = sum[OFS_W-1:0];
  end

  always_comb begin
    case (sch)
      KEY_FSK:  freq_ofs = bit_q ? dev_ext : -dev_ext;
      KEY_GFSK: freq_ofs = ramp;
      default:  freq_ofs = '0;
    endcase
  end

  // next state
  always_comb begin
    start_d = start_q;
    tgt_d   = tgt_q;
    if (!gfsk) begin
      start_d = '0;
      tgt_d   = '0;
    end else if (bit_tick) begin
      start_d = tgt_q;
      tgt_d   = new_tgt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      tgt_q   <= '0;
    end else begin
      start_q <= start_d;
      tgt_q   <= tgt_d;
    end
  end

  AST_RAMP_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (gfsk && bit_tick) |-> (ramp == tgt_q)); // R11
  AST_RAMP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (gfsk && !sub_tick) |=> ($stable(ramp) || !$stable(idx_sel))); // R11
endmodule

// File: rtl/tx_pa_mapper.sv
module tx_pa_mapper
  import tx_key_pkg::*;
#(
  parameter int PWR_W = 7
) (
  input  key_scheme_e       sch,
  input  logic              pa_en,
  input  logic              bit_q,
  input  logic [PWR_W-1:0]  hi_word,
  input  logic [PWR_W-1:0]  lo_word,
  output logic [PWR_W-1:0]  pa_code
);
  localparam int RANGE_LSB = PWR_W - 2;

  logic [PWR_W-1:0] cand;
  logic             range_live;

  always_comb begin
    case (sch)
      KEY_ASK: cand = bit_q ? hi_word : lo_word;
      KEY_OOK: cand = bit_q ? hi_word : '0;
      default: cand = hi_word;
    endcase
    range_live = (cand[PWR_W-1:RANGE_LSB] != 2'b00);
    pa_code    = (pa_en && range_live) ? cand : '0;
  end
endmodule

// File: rtl/tx_keyer.sv
module tx_keyer
  import tx_key_pkg::*;
#(
  parameter int WORD_W        = 7,
  parameter int MOD_W         = 3,
  parameter int DIVF_W        = 7,
  parameter int IDX_W         = 2,
  parameter int IDX_BASE_LOG2 = 4,
  parameter int OFS_W         = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tx_data,
  input  logic                    data_inv,
  input  logic                    pa_en,
  input  logic [1:0]              scheme,
  input  logic [WORD_W-1:0]       dev_word,
  input  logic [WORD_W-1:0]       hi_word,
  input  logic [MOD_W-1:0]        gmod,
  input  logic [DIVF_W-1:0]       div_factor,
  input  logic [IDX_W-1:0]        idx_sel,
  output logic signed [OFS_W-1:0] freq_ofs,
  output logic [WORD_W-1:0]       pa_code,
  output logic                    tx_clk
);
  localparam int SUB_W = IDX_BASE_LOG2 + (1 << IDX_W) - 1;

  key_scheme_e      sch;
  logic             gfsk, data_in, bit_q, bit_d;
  logic             sub_tick, bit_tick;
  logic [SUB_W-1:0] sub_idx;

  always_comb begin
    sch     = key_scheme_e'(scheme);
    gfsk    = (sch == KEY_GFSK);
    data_in = tx_data ^ data_inv;
  end

  // capture once per bit in the smoothed scheme, every cycle otherwise
  always_comb begin
    bit_d = bit_q;
    if (!gfsk || bit_tick) bit_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bit_q <= 1'b0;
    else        bit_q <= bit_d;
  end

  tx_bit_timer #(
    .DIVF_W(DIVF_W), .IDX_W(IDX_W), .IDX_BASE_LOG2(IDX_BASE_LOG2), .SUB_W(SUB_W)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .run(gfsk), .div_factor(div_factor), .idx_sel(idx_sel),
    .sub_tick(sub_tick), .bit_tick(bit_tick), .sub_idx(sub_idx), .tx_clk(tx_clk)
  );

  tx_freq_shaper #(
    .OFS_W(OFS_W), .DEV_W(WORD_W), .MOD_W(MOD_W), .IDX_W(IDX_W),
    .IDX_BASE_LOG2(IDX_BASE_LOG2), .SUB_W(SUB_W)
  ) u_shaper (
    .clk(clk), .rst_n(rst_n), .sch(sch), .bit_q(bit_q), .data_in(data_in),
    .dev_word(dev_word), .gmod(gmod), .sub_tick(sub_tick), .bit_tick(bit_tick),
    .sub_idx(sub_idx), .idx_sel(idx_sel), .freq_ofs(freq_ofs)
  );

  tx_pa_mapper #(.PWR_W(WORD_W)) u_pa (
    .sch(sch), .pa_en(pa_en), .bit_q(bit_q), .hi_word(hi_word),
    .lo_word(dev_word), .pa_code(pa_code)
  );

  AST_PA_RANGE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_code != '0) |-> (pa_code[WORD_W-1:WORD_W-2] != 2'b00)); // R5
  AST_PA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !pa_en |-> (pa_code == '0)); // R6
  AST_GFSK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (gfsk && !bit_tick) |=> $stable(bit_q)); // R12
  AST_NO_CLK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !gfsk |-> !tx_clk); // R10
endmodule

// File: tb/tx_keyer_bench.sv
module tx_keyer_bench;
  logic              clk = 1'b0;
  logic              rst_n;
  logic              tx_data, data_inv, pa_en;
  logic [1:0]        scheme;
  logic [6:0]        dev_word, hi_word;
  logic [2:0]        gmod;
  logic [6:0]        div_factor;
  logic [1:0]        idx_sel;
  logic signed [8:0] freq_ofs;
  logic [6:0]        pa_code;
  logic              tx_clk;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  localparam logic [15:0] PAT = 16'b1011_0011_1000_1101;

  always #4 clk = ~clk;

  tx_keyer u_tx_keyer (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .data_inv(data_inv), .pa_en(pa_en),
    .scheme(scheme), .dev_word(dev_word), .hi_word(hi_word), .gmod(gmod),
    .div_factor(div_factor), .idx_sel(idx_sel), .freq_ofs(freq_ofs),
    .pa_code(pa_code), .tx_clk(tx_clk)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fdiv(input int a, input int b);
    if (a >= 0) return a / b;
    return -((-a + b - 1) / b);
  endfunction

  function automatic int pa_exp(input int sch, input bit d, input bit en,
                                input logic [6:0] lo, input logic [6:0] hi);
    logic [6:0] c;
    if (sch == 2) c = d ? hi : lo;
    else if (sch == 3) c = d ? hi : 7'd0;
    else c = hi;
    if (!en || c[6:5] == 2'b00) return 0;
    return int'(c);
  endfunction

  // R8/R9/R10/R11/R12: one smoothed-keying run of nbits bits
  task automatic run_gfsk(input int div, input int isel, input int m, input bit inv, input int nbits);
    int deff, idx, per, total;
    deff  = (div == 0) ? 1 : div;
    idx   = 16 << isel;
    per   = deff * idx;
    total = nbits * per;
    @(negedge clk);
    scheme = 2'b00; div_factor = 7'(div); idx_sel = 2'(isel); gmod = 3'(m);
    data_inv = inv; pa_en = 1'b1; hi_word = 7'h45;
    @(negedge clk);
    scheme  = 2'b01;
    tx_data = ((per == 1) ? PAT[0] : ~PAT[0]);
    for (int n = 1; n <= total; n++) begin
      int b, s, tgt, st, e, j;
      @(posedge clk);
      @(negedge clk);
      b  = n / per;
      s  = (n / deff) % idx;
      tgt = (b >= 1) ? (((PAT[(b-1)%16] ^ inv) != 0) ? (1 << m) : -(1 << m)) : 0;
      st  = (b >= 2) ? (((PAT[(b-2)%16] ^ inv) != 0) ? (1 << m) : -(1 << m)) : 0;
      e  = st + fdiv((tgt - st) * (s + 1), idx);
      chk("R8/R11/R12 gfsk offset", int'(freq_ofs), e);
      chk("R9/R10 tx_clk phase", int'(tx_clk), (s < idx / 2) ? 1 : 0);
      j = n / per;
      tx_data = (((n + 1) % per) == 0) ? PAT[j % 16] : ~PAT[j % 16];
    end
    chk("R6 gfsk pa", int'(pa_code), int'(7'h45));
    scheme = 2'b00;
    @(posedge clk);
    @(negedge clk);
    chk("R10 tx_clk idle", int'(tx_clk), 0);
  endtask

  initial begin
    rst_n = 1'b0; tx_data = 1'b0; data_inv = 1'b0; pa_en = 1'b1; scheme = 2'b11;
    dev_word = 7'd9; hi_word = 7'h7F; gmod = 3'd0; div_factor = 7'd2; idx_sel = 2'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state in on/off keying
    chk("R1 reset ofs", int'(freq_ofs), 0);
    chk("R1 reset pa", int'(pa_code), 0);
    chk("R1 reset tx_clk", int'(tx_clk), 0);
    rst_n = 1'b1;

    // R1..R7 sweep of the per-cycle schemes
    for (int si = 0; si < 3; si++) begin
      for (int w = 0; w < 4; w++) begin
        for (int d = 0; d < 2; d++) begin
          for (int iv = 0; iv < 2; iv++) begin
            for (int en = 0; en < 2; en++) begin
              int sch, eo;
              bit dd;
              logic [6:0] dv, hv;
              string tg;
              sch = (si == 0) ? 0 : si + 1;
              case (w)
                0: begin dv = 7'h05; hv = 7'h1F; end
                1: begin dv = 7'h7F; hv = 7'h3A; end
                2: begin dv = 7'd33; hv = 7'h61; end
                default: begin dv = 7'd0; hv = 7'h7E; end
              endcase
              @(negedge clk);
              scheme = 2'(sch); dev_word = dv; hi_word = hv;
              tx_data = d[0]; data_inv = iv[0]; pa_en = en[0];
              @(posedge clk);
              @(negedge clk);
              dd = d[0] ^ iv[0];
              eo = (sch == 0) ? (dd ? int'(dv) : -int'(dv)) : 0;
              tg = (iv != 0) ? "R7" : ((sch == 0) ? "R2" : ((sch == 2) ? "R3" : "R4"));
              chk({tg, " offset"}, int'(freq_ofs), eo);
              tg = (en == 0) ? "R6" : ((sch == 0) ? "R5" : ((sch == 2) ? "R3/R5" : "R4/R5"));
              chk({tg, " pa code"}, int'(pa_code), pa_exp(sch, dd, en[0], dv, hv));
            end
          end
        end
      end
    end

    // smoothed keying sweeps
    for (int m = 0; m < 8; m++) run_gfsk(2, 0, m, 1'b0, 4);
    run_gfsk(3, 1, 3, 1'b1, 4);
    run_gfsk(0, 3, 7, 1'b0, 5);   // R9 divider 0 acts as 1
    run_gfsk(1, 2, 5, 1'b1, 3);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule